// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading one or two word-wide descriptors from a translation table kept in memory. A table base input gives the table's physical location, which is aligned to 16KB. When a request is accepted, the walker reads one first-level descriptor, one for each 1MB region of virtual space, and decodes its two low bits. A section descriptor completes the translation at once. A coarse descriptor supplies the base of a second-level table, and the walker makes a second, dependent read there to find a 4KB small-page descriptor. Invalid types end the walk with a fault.

The walker handles one translation at a time. Its control is a six-state machine. IDLE keeps ready high and accepts a request (transition IDLE→L1_ISSUE). L1_ISSUE drives a one-cycle read strobe (→L1_WAIT). L1_WAIT waits for read data. A section or a fault goes to RESP, and a coarse pointer goes to L2_ISSUE. L2_ISSUE drives the second strobe (→L2_WAIT). L2_WAIT waits for the page descriptor (→RESP). RESP presents the result for one cycle (→IDLE). The physical address, the attribute field and the fault flag stay registered on the outputs until the next response.

Top module: `ttw_walker`

## Requirements
- R1: While reset is asserted and in the first cycle after it, req_ready_o is 1, and mem_req_o and rsp_valid_o are 0.
- R2: A request is accepted on a clock edge where req_valid_i and req_ready_o are both 1. After that, req_ready_o stays 0 up to and including the cycle where rsp_valid_o is 1. rsp_valid_o is a one-cycle pulse, and req_ready_o is 1 again in the next cycle.
- R3: The first read is a one-cycle mem_req_o pulse in the cycle after acceptance. Its address is {base[31:14], va[31:20], 2'b00}, so the entry for VA 0x00100000–0x001FFFFF lies at base+4.
- R4: The descriptor type is bits [1:0]. At the first level, 01 means a coarse pointer, 10 means a section, and 00 or 11 means a fault.
- R5: A first-level section gives rsp_pa_o = {desc[31:20], va[19:0]}, rsp_attr_o = desc[11:2] and rsp_fault_o = 0, after exactly one read.
- R6: A first-level coarse pointer causes a second one-cycle read at {desc[31:10], va[19:12], 2'b00}.
- R7: A second-level descriptor whose bit 1 is 1 (type 10 or 11) is a small page and gives rsp_pa_o = {desc[31:12], va[11:0]}, rsp_attr_o = desc[11:2] and rsp_fault_o = 0.
- R8: A fault gives rsp_fault_o = 1 with rsp_pa_o = 0 and rsp_attr_o = 0, and no further read follows. Faults come from first-level types 00 and 11 and from second-level types 00 and 01.
- R9: The walker decodes only on a cycle where mem_rvalid_i is 1, whatever the read latency. No response appears before the last read returns.
- R10: Bits [13:0] of tbl_base_i have no effect on any read address or result.
- R11: rsp_pa_o, rsp_attr_o and rsp_fault_o keep their values between responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_base_i | input | 32 | Physical base of the first-level table, sampled at acceptance |
| req_valid_i | input | 1 | Translation request valid |
| req_va_i | input | 32 | Virtual address to translate |
| req_ready_o | output | 1 | Walker idle and able to accept |
| mem_req_o | output | 1 | One-cycle descriptor read strobe |
| mem_addr_o | output | 32 | Descriptor read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Descriptor word |
| rsp_valid_o | output | 1 | One-cycle response pulse |
| rsp_pa_o | output | 32 | Translated physical address |
| rsp_attr_o | output | 10 | Attribute bits of the final descriptor |
| rsp_fault_o | output | 1 | Translation fault |

## Verification
The assertions assume that the memory returns exactly one mem_rvalid_i pulse for each read strobe, at least one cycle after the strobe, and never while the walker is idle or waiting to issue. They also assume that the request address stays stable only at the acceptance edge. The bench's memory model follows these rules. It captures each strobe's address, waits a chosen latency of one or more cycles, and then drives a single data-valid pulse. Requests are raised only while ready is seen high, and the table base changes only between walks.

// File: rtl/ttw_pkg.sv
package ttw_pkg;
    localparam int ADDR_W      = 32;
    localparam int ALIGN_W     = 14;
    localparam int L1_IDX_W    = 12;
    localparam int SEC_OFF_W   = ADDR_W - L1_IDX_W;
    localparam int PAGE_OFF_W  = 12;
    localparam int L2_IDX_W    = SEC_OFF_W - PAGE_OFF_W;
    localparam int COARSE_LO   = L2_IDX_W + 2;
    localparam int ATTR_LO     = 2;
    localparam int ATTR_HI     = 11;
    localparam int ATTR_W      = ATTR_HI - ATTR_LO + 1;

    typedef enum logic [1:0] {
        DT_INVALID = 2'b00,
        DT_COARSE  = 2'b01,
        DT_SECTION = 2'b10,
        DT_RSVD    = 2'b11
    } desc_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_ISSUE,
        S_L1_WAIT,
        S_L2_ISSUE,
        S_L2_WAIT,
        S_RESP
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        logic [ATTR_W-1:0] attr;
        logic              fault;
    } walk_result_t;
endpackage

// File: rtl/ttw_addr.sv
module ttw_addr
    import ttw_pkg::*;
(
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] va_i,
    input  logic [ADDR_W-1:0] coarse_desc_i,
    input  logic              use_l2_i,
    output logic [ADDR_W-1:0] fetch_addr_o
);
    logic [ADDR_W-1:0] l1_addr;
    logic [ADDR_W-1:0] l2_addr;

    always_comb begin
        l1_addr = {base_i[ADDR_W-1:ALIGN_W], va_i[ADDR_W-1:SEC_OFF_W], 2'b00};
        l2_addr = {coarse_desc_i[ADDR_W-1:COARSE_LO],
                   va_i[SEC_OFF_W-1:PAGE_OFF_W], 2'b00};
        fetch_addr_o = use_l2_i ? l2_addr : l1_addr;
    end
endmodule

// File: rtl/ttw_decode.sv
module ttw_decode
    import ttw_pkg::*;
(
    input  logic              second_level_i,
    input  logic [ADDR_W-1:0] desc_i,
    input  logic [ADDR_W-1:0] va_i,
    output logic              go_l2_o,
    output walk_result_t      result_o
);
    desc_kind_e kind;
    walk_result_t fault_res;

    always_comb begin
        kind      = desc_kind_e'(desc_i[1:0]);
        fault_res = '{pa: '0, attr: '0, fault: 1'b1};
        go_l2_o   = 1'b0;
        result_o  = fault_res;
        if (!second_level_i) begin
            unique case (kind)
                DT_SECTION: begin
                    result_o.pa    = {desc_i[ADDR_W-1:SEC_OFF_W], va_i[SEC_OFF_W-1:0]};
                    result_o.attr  = desc_i[ATTR_HI:ATTR_LO];
                    result_o.fault = 1'b0;
                end
                DT_COARSE:  go_l2_o = 1'b1;
                DT_INVALID,
                DT_RSVD:    result_o = fault_res;
            endcase
        end else if (desc_i[1]) begin
            result_o.pa    = {desc_i[ADDR_W-1:PAGE_OFF_W], va_i[PAGE_OFF_W-1:0]};
            result_o.attr  = desc_i[ATTR_HI:ATTR_LO];
            result_o.fault = 1'b0;
        end
    end

    // R8: a decoded fault never carries an address or attributes
    always_comb begin
        a_r8_fault_clean: assert (!result_o.fault || (result_o.pa == '0 && result_o.attr == '0));
    end
endmodule

// File: rtl/ttw_ctrl.sv
module ttw_ctrl
    import ttw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    input  logic rvalid_i,
    input  logic go_l2_i,
    output logic ready_o,
    output logic mem_req_o,
    output logic rsp_valid_o,
    output logic use_l2_o,
    output logic second_level_o,
    output logic cap_req_o,
    output logic cap_coarse_o,
    output logic cap_result_o
);
    walk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (req_valid_i) state_d = S_L1_ISSUE;
            S_L1_ISSUE: state_d = S_L1_WAIT;
            S_L1_WAIT:  if (rvalid_i) state_d = go_l2_i ? S_L2_ISSUE : S_RESP;
            S_L2_ISSUE: state_d = S_L2_WAIT;
            S_L2_WAIT:  if (rvalid_i) state_d = S_RESP;
            S_RESP:     state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        ready_o        = 1'b0;
        mem_req_o      = 1'b0;
        rsp_valid_o    = 1'b0;
        use_l2_o       = 1'b0;
        second_level_o = 1'b0;
        cap_req_o      = 1'b0;
        cap_coarse_o   = 1'b0;
        cap_result_o   = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                ready_o   = 1'b1;
                cap_req_o = req_valid_i;
            end
            S_L1_ISSUE: mem_req_o = 1'b1;
            S_L1_WAIT: begin
                cap_coarse_o = rvalid_i && go_l2_i;
                cap_result_o = rvalid_i && !go_l2_i;
            end
            S_L2_ISSUE: begin
                mem_req_o = 1'b1;
                use_l2_o  = 1'b1;
            end
            S_L2_WAIT: begin
                use_l2_o       = 1'b1;
                second_level_o = 1'b1;
                cap_result_o   = rvalid_i;
            end
            S_RESP: rsp_valid_o = 1'b1;
            default: ;
        endcase
    end

    // R2: acceptance drops ready at once
    a_r2_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && ready_o) |=> !ready_o);
    // R2: response is a single pulse, and ready returns right after it
    a_r2_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> (!rsp_valid_o && ready_o));
    // R2: ready is never high while a response is presented
    a_r2_rsp_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> !ready_o);
    // R3: each read strobe lasts one cycle
    a_r3_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);
    // R9: a read strobe is never followed directly by a response
    a_r9_no_early_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !rsp_valid_o);
endmodule

// File: rtl/ttw_walker.sv
module ttw_walker
    import ttw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       tbl_base_i,
    input  logic              req_valid_i,
    input  logic [31:0]       req_va_i,
    output logic              req_ready_o,
    output logic              mem_req_o,
    output logic [31:0]       mem_addr_o,
    input  logic              mem_rvalid_i,
    input  logic [31:0]       mem_rdata_i,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_pa_o,
    output logic [9:0]        rsp_attr_o,
    output logic              rsp_fault_o
);
    logic [ADDR_W-1:0] va_q, base_q, coarse_q;
    walk_result_t      res_q, dec_res;
    logic use_l2, second_level, go_l2;
    logic cap_req, cap_coarse, cap_result;

    ttw_ctrl u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid_i    (req_valid_i),
        .rvalid_i       (mem_rvalid_i),
        .go_l2_i        (go_l2),
        .ready_o        (req_ready_o),
        .mem_req_o      (mem_req_o),
        .rsp_valid_o    (rsp_valid_o),
        .use_l2_o       (use_l2),
        .second_level_o (second_level),
        .cap_req_o      (cap_req),
        .cap_coarse_o   (cap_coarse),
        .cap_result_o   (cap_result)
    );

    ttw_addr u_addr (
        .base_i        (base_q),
        .va_i          (va_q),
        .coarse_desc_i (coarse_q),
        .use_l2_i      (use_l2),
        .fetch_addr_o  (mem_addr_o)
    );

    ttw_decode u_dec (
        .second_level_i (second_level),
        .desc_i         (mem_rdata_i),
        .va_i           (va_q),
        .go_l2_o        (go_l2),
        .result_o       (dec_res)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q     <= '0;
            base_q   <= '0;
            coarse_q <= '0;
            res_q    <= '0;
        end else begin
            if (cap_req) begin
                va_q   <= req_va_i;
                base_q <= tbl_base_i;
            end
            if (cap_coarse) coarse_q <= mem_rdata_i;
            if (cap_result) res_q    <= dec_res;
        end
    end

    assign rsp_pa_o    = res_q.pa;
    assign rsp_attr_o  = res_q.attr;
    assign rsp_fault_o = res_q.fault;

    // R3, R6: every read address is word aligned
    a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> (mem_addr_o[1:0] == 2'b00));
    // R8: a faulting response carries no address and no attributes
    a_r8_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid_o && rsp_fault_o) |-> (rsp_pa_o == '0 && rsp_attr_o == '0));
    // R11: results change only when a response is presented
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid_o |-> ($stable(rsp_pa_o) && $stable(rsp_attr_o) && $stable(rsp_fault_o)));
endmodule

// File: tb/sim_ttw_walker.sv
module sim_ttw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] tbl_base_i = 32'h4020_0000;
    logic        req_valid_i = 1'b0;
    logic [31:0] req_va_i = '0;
    logic        req_ready_o, mem_req_o, mem_rvalid_i, rsp_valid_o, rsp_fault_o;
    logic [31:0] mem_addr_o, mem_rdata_i, rsp_pa_o;
    logic [9:0]  rsp_attr_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    ttw_walker u0 (
        .clk(clk), .rst_n(rst_n), .tbl_base_i(tbl_base_i),
        .req_valid_i(req_valid_i), .req_va_i(req_va_i), .req_ready_o(req_ready_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
        .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
        .rsp_valid_o(rsp_valid_o), .rsp_pa_o(rsp_pa_o),
        .rsp_attr_o(rsp_attr_o), .rsp_fault_o(rsp_fault_o)
    );

    // memory model
    logic [31:0] mem [logic [31:0]];
    int          mem_lat = 1;
    int          lat_cnt = 0;
    int          fetch_n = 0;
    logic [31:0] pend_addr = '0;
    logic [31:0] fetch_a1 = '0, fetch_a2 = '0;

    initial begin
        mem_rvalid_i = 1'b0;
        mem_rdata_i  = '0;
    end

    always @(negedge clk) begin
        mem_rvalid_i = 1'b0;
        if (mem_req_o) begin
            pend_addr = mem_addr_o;
            lat_cnt   = mem_lat;
            fetch_n++;
            if (fetch_n == 1) fetch_a1 = mem_addr_o;
            else              fetch_a2 = mem_addr_o;
        end else if (lat_cnt > 0) begin
            lat_cnt--;
            if (lat_cnt == 0) begin
                mem_rvalid_i = 1'b1;
                mem_rdata_i  = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    logic [31:0] r_pa;
    logic [9:0]  r_attr;
    logic        r_fault;

    task automatic walk(input logic [31:0] va, input int lat);
        int wait_n;
        @(negedge clk);
        while (!req_ready_o) @(negedge clk);
        req_valid_i = 1'b1;
        req_va_i    = va;
        mem_lat     = lat;
        fetch_n     = 0;
        @(negedge clk);
        req_valid_i = 1'b0;
        req_va_i    = 32'hDEAD_BEEF;
        wait_n = 0;
        while (!rsp_valid_o && wait_n < 200) begin
            chk(!req_ready_o, "R2 ready low while busy", {31'b0, req_ready_o}, 32'h0);
            @(negedge clk);
            wait_n++;
        end
        chk(rsp_valid_o && !req_ready_o, "R2 response with ready low",
            {30'b0, rsp_valid_o, req_ready_o}, 32'h2);
        r_pa = rsp_pa_o; r_attr = rsp_attr_o; r_fault = rsp_fault_o;
        @(negedge clk);
        chk(req_ready_o && !rsp_valid_o, "R2 ready back, pulse ended",
            {30'b0, rsp_valid_o, req_ready_o}, 32'h1);
        chk(rsp_pa_o == r_pa && rsp_attr_o == r_attr && rsp_fault_o == r_fault,
            "R11 result held", rsp_pa_o, r_pa);
    endtask

    // vector table: va, expected pa, attr, fault, reads, second read address
    localparam int NV = 8;
    localparam logic [31:0] V_VA [NV] = '{32'h0011_2345, 32'h4023_4567, 32'h4023_5ABC,
        32'h4023_6000, 32'h7FF0_0000, 32'h0020_0010, 32'hFFFF_FFFF, 32'h0000_0000};
    localparam logic [31:0] V_PA [NV] = '{32'h8011_2345, 32'h1234_5567, 32'h0ABC_DABC,
        32'h0, 32'h0, 32'h0, 32'h000F_FFFF, 32'hFFF0_0000};
    localparam logic [9:0] V_AT [NV] = '{10'h303, 10'h29F, 10'h0FD, 10'h0, 10'h0, 10'h0, 10'h104, 10'h0};
    localparam logic V_FT [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
    localparam int V_NF [NV] = '{1, 2, 2, 2, 1, 1, 1, 1};
    localparam logic [31:0] V_A2 [NV] = '{32'h0, 32'h4030_00D0, 32'h4030_00D4,
        32'h4030_00D8, 32'h0, 32'h0, 32'h0, 32'h0};
    localparam string V_TAG [NV] = '{"R5 section", "R7 small page 10", "R7 small page 11",
        "R8 L2 fault", "R8 L1 type 00", "R8 L1 type 11", "R5 top section", "R5 bottom section"};

    initial begin
        logic [31:0] base, exp_a1;
        // table contents
        mem[32'h4020_0004] = 32'h8010_0C0E;  // section
        mem[32'h4020_1008] = 32'h4030_0001;  // coarse pointer
        mem[32'h4030_00D0] = 32'h1234_5A7E;  // small page type 10
        mem[32'h4030_00D4] = 32'h0ABC_D3F7;  // small page type 11
        mem[32'h4030_00D8] = 32'h0000_0000;  // L2 fault
        mem[32'h4020_1FFC] = 32'h0000_0000;  // L1 fault 00
        mem[32'h4020_0008] = 32'hFFF0_0FFF;  // L1 fault 11
        mem[32'h4020_3FFC] = 32'h0000_0412;  // section at top
        mem[32'h4020_0000] = 32'hFFF0_0002;  // section at bottom

        // R1 reset state
        repeat (3) @(negedge clk);
        chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R1 reset outputs",
            {29'b0, req_ready_o, mem_req_o, rsp_valid_o}, 32'h4);
        @(negedge clk); rst_n = 1'b1;
        chk(req_ready_o && !mem_req_o && !rsp_valid_o, "R1 after reset",
            {29'b0, req_ready_o, mem_req_o, rsp_valid_o}, 32'h4);

        // vector loop (R4..R9 with varying latency)
        base = 32'h4020_0000;
        for (int i = 0; i < NV; i++) begin
            tbl_base_i = base;
            walk(V_VA[i], 1 + (i % 4));
            exp_a1 = base + (V_VA[i] >> 20) * 4;
            chk(fetch_a1 == exp_a1, {"R3 first read ", V_TAG[i]}, fetch_a1, exp_a1);
            chk(fetch_n == V_NF[i], {"R4 read count ", V_TAG[i]}, fetch_n, V_NF[i]);
            if (V_NF[i] == 2)
                chk(fetch_a2 == V_A2[i], {"R6 second read ", V_TAG[i]}, fetch_a2, V_A2[i]);
            chk(r_pa == V_PA[i], {"R5/R7 pa ", V_TAG[i]}, r_pa, V_PA[i]);
            chk(r_attr == V_AT[i], {"R5/R7 attr ", V_TAG[i]}, {22'b0, r_attr}, {22'b0, V_AT[i]});
            chk(r_fault == V_FT[i], {"R8 fault ", V_TAG[i]}, {31'b0, r_fault}, {31'b0, V_FT[i]});
        end

        // R10: low base bits ignored
        tbl_base_i = 32'h4020_3FFF;
        walk(32'h0011_2345, 2);
        chk(fetch_a1 == 32'h4020_0004, "R10 low base bits first read", fetch_a1, 32'h4020_0004);
        chk(r_pa == 32'h8011_2345, "R10 low base bits pa", r_pa, 32'h8011_2345);

        // R9: long latency on a two-level walk
        tbl_base_i = 32'h4020_0000;
        walk(32'h4023_4567, 7);
        chk(fetch_n == 2, "R9 long latency reads", fetch_n, 2);
        chk(r_pa == 32'h1234_5567, "R9 long latency pa", r_pa, 32'h1234_5567);

        // R11: fault result held over idle cycles
        walk(32'h7FF0_0000, 1);
        repeat (4) @(negedge clk);
        chk(rsp_fault_o && rsp_pa_o == 32'h0, "R11 fault held in idle",
            {31'b0, rsp_fault_o}, 32'h1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule